// File: doc/BRIEF.md
# Serial FM Sample Shifter

This block sits at the digital edge of a receiver and hands the modem one 8-bit FM sample per frame, for the I lane and the Q lane at the same time, one bit at a time. The modem supplies a slow bit clock and a frame strobe. The block runs on its own fast clock. It resynchronizes both control lines and acts on each falling edge of the bit clock.

A frame starts when the strobe is seen high at a bit-clock falling edge, having been low at the previous falling edge. A frame lasts nine bit periods. The first slot carries no data and is driven low. The next eight slots carry the byte, most significant bit first. Between frames the serial lines rest low.

Samples enter through a valid/ready port into a one-entry holding slot. A frame start moves the held sample into the shift registers. The two serial lines share their pins with two lines of a CDMA parallel data bus. A mode input picks which source drives the pins. While the block is outside FM mode, the serial logic is held cleared.

Top module: `fmsamp_serializer`

## Requirements
- R1: After reset with `fm_mode` high, `pin_out` is 2'b00 and `smp_ready` is 1.
- R2: A frame starts at a bit-clock falling edge where `frame_stb` is high, provided it was low at the previous falling edge. The first slot of the frame drives both serial lines low.
- R3: The eight slots after the first carry the byte from bit 7 down to bit 0. `pin_out[1]` carries the I lane, which is `smp_data[15:8]`. `pin_out[0]` carries the Q lane, which is `smp_data[7:0]`.
- R4: `pin_out` changes in FM mode only because of a bit-clock falling edge. The new value is visible after the third rising edge of `clk` that follows that falling edge.
- R5: Outside a frame, both serial lines stay low. This covers the time from the end of the D0 slot until the next frame start.
- R6: A frame that starts with no sample held shifts out all zeros.
- R7: A sample accepted while a frame is shifting does not change that frame. It is sent in the next frame.
- R8: `smp_ready` is high exactly while the holding slot is empty in FM mode. It falls in the cycle after a handshake. It rises again in the cycle after a frame start takes the held sample.
- R9: If a handshake and a frame start occur in the same `clk` cycle while the slot is empty, the frame carries that sample. `smp_ready` stays high.
- R10: With `fm_mode` low, `pin_out` equals `cdma_bits` and `smp_ready` is 0. The holding slot and the shifters are cleared. After a return to FM mode, the lines are low and a held sample from before the mode change is gone.
- R11: A strobe that is still high at the falling edge after a frame start does not restart the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| fm_mode | input | 1 | 1: pins carry the serial FM data; 0: pins carry the CDMA bits |
| bit_clk | input | 1 | Bit clock from the modem (asynchronous) |
| frame_stb | input | 1 | Frame strobe from the modem (asynchronous) |
| smp_data | input | 16 | I byte in [15:8], Q byte in [7:0] |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Holding slot can take a sample |
| cdma_bits | input | 2 | CDMA parallel I-bus bits 1 and 0 |
| pin_out | output | 2 | Shared pins: [1] I serial / CDMA bit 1, [0] Q serial / CDMA bit 0 |

## Verification
A sample handshake and a frame start can land in the same `clk` cycle. In that case the incoming sample must go straight into the shifters and must not pass through the holding slot. The bench provokes this by raising `smp_valid` exactly in the cycle where the resynchronized falling edge is recognized, which is two `clk` edges after the bit clock drops. It judges the result by checking that the frame that follows carries that sample and that `smp_ready` is still high right after the handshake.

// File: rtl/fmss_pkg.sv
package fmss_pkg;
  // Resynchronizer depth for the modem-side clock and strobe.
  localparam int unsigned SYNC_DEPTH = 2;
  // Number of clk edges from a bit-clock fall to the updated serial output.
  localparam int unsigned EDGE_LAT   = SYNC_DEPTH + 1;
  // Data slots per frame; one lead slot precedes them.
  function automatic int unsigned slot_bits(input int unsigned width);
    return $clog2(width + 1);
  endfunction
endpackage

// File: rtl/fmss_edge_sense.sv
module fmss_edge_sense #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_clk,
  input  logic frame_stb,
  output logic bit_fall,
  output logic frame_start
);
  // bclk_sh[0..DEPTH-1] resynchronize; bclk_sh[DEPTH] holds the previous value.
  logic [DEPTH:0]   bclk_sh;
  logic [DEPTH-1:0] stb_sh;
  logic             stb_prev;
  logic             stb_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_sh  <= '0;
      stb_sh   <= '0;
      stb_prev <= 1'b0;
    end else if (clr) begin
      bclk_sh  <= '0;
      stb_sh   <= '0;
      stb_prev <= 1'b0;
    end else begin
      bclk_sh <= {bclk_sh[DEPTH-1:0], bit_clk};
      stb_sh  <= {stb_sh[DEPTH-2:0], frame_stb};
      if (bit_fall) stb_prev <= stb_now;
    end
  end

  assign stb_now     = stb_sh[DEPTH-1];
  assign bit_fall    = bclk_sh[DEPTH] & ~bclk_sh[DEPTH-1];
  // Only a strobe that was low at the previous fall opens a frame.
  assign frame_start = bit_fall & stb_now & ~stb_prev;
endmodule

// File: rtl/fmss_sample_slot.sv
module fmss_sample_slot #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         take,
  output logic [W-1:0] load_data
);
  logic         full;
  logic [W-1:0] hold;
  logic         hs;

  assign in_ready = ~full & ~clr;
  assign hs       = in_valid & in_ready;
  // Held sample first; otherwise a same-cycle handshake bypasses; else zeros.
  assign load_data = full ? hold : (hs ? in_data : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      hold <= '0;
    end else if (clr) begin
      full <= 1'b0;
      hold <= '0;
    end else if (take) begin
      full <= 1'b0;
      hold <= '0;
    end else if (hs) begin
      full <= 1'b1;
      hold <= in_data;
    end
  end
endmodule

// File: rtl/fmss_lane_shifter.sv
module fmss_lane_shifter
  import fmss_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_fall,
  input  logic         frame_start,
  input  logic [W-1:0] load_byte,
  output logic         ser_out
);
  localparam int unsigned CW = slot_bits(W);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [W-1:0]  sreg;
  logic [CW-1:0] slot;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0; slot <= '0; busy <= 1'b0; ser_out <= 1'b0;
    end else if (clr) begin
      sreg <= '0; slot <= '0; busy <= 1'b0; ser_out <= 1'b0;
    end else if (frame_start) begin
      sreg    <= load_byte;
      slot    <= '0;
      busy    <= 1'b1;
      ser_out <= 1'b0;              // lead slot carries no data
    end else if (bit_fall && busy) begin
      if (slot < LAST) begin
        ser_out <= sreg[W-1];
        sreg    <= {sreg[W-2:0], 1'b0};
        slot    <= slot + 1'b1;
      end else begin
        ser_out <= 1'b0;            // back to idle after the last bit
        busy    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fmss_pin_mux.sv
module fmss_pin_mux #(
  parameter int unsigned LANES = 2
) (
  input  logic             fm_mode,
  input  logic [LANES-1:0] ser_bits,
  input  logic [LANES-1:0] cdma_bits,
  output logic [LANES-1:0] pin_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_pin
    assign pin_out[g] = fm_mode ? ser_bits[g] : cdma_bits[g];
  end
endmodule

// File: rtl/fmsamp_serializer.sv
module fmsamp_serializer
  import fmss_pkg::*;
#(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned LANES = 2,
  localparam int unsigned BUS_W = SMP_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fm_mode,
  input  logic             bit_clk,
  input  logic             frame_stb,
  input  logic [BUS_W-1:0] smp_data,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [LANES-1:0] cdma_bits,
  output logic [LANES-1:0] pin_out
);
  logic             clr;
  logic             bit_fall;
  logic             frame_start;
  logic [BUS_W-1:0] load_data;
  logic [LANES-1:0] ser_bits;

  assign clr = ~fm_mode;

  fmss_edge_sense #(.DEPTH(SYNC_DEPTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bit_clk(bit_clk), .frame_stb(frame_stb),
    .bit_fall(bit_fall), .frame_start(frame_start)
  );

  fmss_sample_slot #(.W(BUS_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_data(smp_data), .in_valid(smp_valid), .in_ready(smp_ready),
    .take(frame_start), .load_data(load_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fmss_lane_shifter #(.W(SMP_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .bit_fall(bit_fall), .frame_start(frame_start),
      .load_byte(load_data[g*SMP_W +: SMP_W]),
      .ser_out(ser_bits[g])
    );
  end

  fmss_pin_mux #(.LANES(LANES)) u_mux (
    .fm_mode(fm_mode), .ser_bits(ser_bits),
    .cdma_bits(cdma_bits), .pin_out(pin_out)
  );
endmodule

// File: rtl/fmss_checks.sv
module fmss_checks #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fm_mode,
  input logic             bit_clk,
  input logic             smp_valid,
  input logic             smp_ready,
  input logic [LANES-1:0] pin_out,
  input logic             frame_start,
  input logic [LANES-1:0] ser_bits
);
  // Lead slot after a frame start is low on every lane.
  assert_lead_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (ser_bits == '0));

  // Pins move in FM mode only as the delayed result of a bit-clock fall
  // (two resynchronizer stages plus the output register).
  assert_edge_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_mode && $past(fm_mode) && (pin_out != $past(pin_out)))
      |-> ($past(bit_clk, 4) && !$past(bit_clk, 3)));

  // A handshake outside a frame start fills the slot.
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && !frame_start) |=> !smp_ready);

  // A handshake coinciding with a frame start bypasses the slot.
  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && frame_start && fm_mode) |=> (smp_ready || !fm_mode));

  // Outside FM mode the serial side is quiet and closed.
  assert_nonfm_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fm_mode && $past(!fm_mode)) |-> (!smp_ready && !frame_start && ser_bits == '0));
endmodule

bind fmsamp_serializer fmss_checks #(.LANES(LANES)) u_fmss_checks (
  .clk(clk), .rst_n(rst_n), .fm_mode(fm_mode), .bit_clk(bit_clk),
  .smp_valid(smp_valid), .smp_ready(smp_ready), .pin_out(pin_out),
  .frame_start(frame_start), .ser_bits(ser_bits)
);

// File: tb/fmsamp_serializer_bench.sv
module fmsamp_serializer_bench;
  localparam int HB = 8;  // half bit period in clk cycles

  logic        clk = 0, rst_n = 0, fm_mode = 1, bit_clk = 0, frame_stb = 0;
  logic        smp_valid = 0;
  logic [15:0] smp_data = '0;
  logic [1:0]  cdma_bits = '0;
  logic        smp_ready;
  logic [1:0]  pin_out;

  fmsamp_serializer u_fmsamp_serializer (
    .clk(clk), .rst_n(rst_n), .fm_mode(fm_mode), .bit_clk(bit_clk),
    .frame_stb(frame_stb), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .cdma_bits(cdma_bits), .pin_out(pin_out)
  );

  always #2 clk = ~clk;  // 250 MHz

  int          checks = 0, fails = 0;
  bit          done = 0, mon_en = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 0;
  logic [15:0] pend_data = '0;

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: offer a sample, wait for the handshake, record it as held.
  task automatic send(input logic [15:0] d);
    smp_data  = d;
    smp_valid = 1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 0;
    pend = 1; pend_data = d;
    check(smp_ready == 0, "R8 ready low while held", {15'd0, smp_ready}, 16'd0);
  endtask

  // One bit period; the falling edge is at index HB.
  task automatic slot(input bit stb, input bit hold_stb, input bit byp, input logic [15:0] bd);
    for (int k = 0; k < 2*HB; k++) begin
      if (k == 0) bit_clk = 1;
      if (k == HB/2 && stb) frame_stb = 1;
      if (k == HB) bit_clk = 0;
      if (byp && k == HB+2) begin smp_data = bd; smp_valid = 1; end
      if (byp && k == HB+3) begin
        smp_valid = 0;
        check(smp_ready == 1, "R9 ready stays high on bypass", {15'd0, smp_ready}, 16'd1);
      end
      if (k == HB + HB/2 && !hold_stb) frame_stb = 0;
      @(negedge clk);
    end
  endtask

  task automatic frame(input string tag);
    bit had = pend;
    exp_q.push_back(pend ? pend_data : 16'h0000);
    tag_q.push_back(tag);
    pend = 0;
    slot(1, 0, 0, '0);
    if (had) check(smp_ready == 1, "R8 ready back after frame start", {15'd0, smp_ready}, 16'd1);
    repeat (8) slot(0, 0, 0, '0);
  endtask

  // Monitor: rebuild frames from the pins and compare with the queue.
  initial begin
    int          slot_n;
    logic        prev_s, s_at, fr;
    logic [1:0]  last, v;
    logic [15:0] got, e;
    string       t;
    slot_n = 99; prev_s = 0; last = 0; got = 0;
    forever begin
      @(negedge bit_clk);
      if (!mon_en) begin slot_n = 99; prev_s = 0; last = 0; continue; end
      s_at = frame_stb; fr = s_at && !prev_s; prev_s = s_at;
      repeat (2) @(negedge clk);
      check(pin_out == last, "R4 no change before third clk edge", {14'd0, pin_out}, {14'd0, last});
      @(negedge clk);
      v = pin_out;
      if (fr) begin
        slot_n = 0; got = 0;
        check(v == 2'b00, "R2 lead slot low", {14'd0, v}, 16'd0);
      end else if (slot_n < 8) begin
        slot_n++;
        got[8 + 8 - slot_n] = v[1];
        got[8 - slot_n]     = v[0];
        if (slot_n == 8) begin
          if (exp_q.size() == 0) check(0, "R3 unexpected frame", got, 16'h0);
          else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(got == e, t, got, e);
          end
        end
      end else begin
        check(v == 2'b00, "R5 idle low", {14'd0, v}, 16'd0);
      end
      last = v;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(pin_out == 2'b00, "R1 reset pins", {14'd0, pin_out}, 16'd0);
    check(smp_ready == 1, "R1 reset ready", {15'd0, smp_ready}, 16'd1);
    mon_en = 1;
    repeat (2) slot(0, 0, 0, '0);                   // R5 idle before any frame

    send(16'hA53C); frame("R3 pattern A53C");
    send(16'hFF00); frame("R3 pattern FF00");
    send(16'h817E); frame("R3 pattern 817E");
    frame("R6 empty slot shifts zeros");

    // R7: new sample mid-frame
    send(16'h1122);
    exp_q.push_back(16'h1122); tag_q.push_back("R7 current frame undisturbed"); pend = 0;
    slot(1, 0, 0, '0);
    repeat (3) slot(0, 0, 0, '0);
    check(smp_ready == 1, "R8 ready high when empty", {15'd0, smp_ready}, 16'd1);
    send(16'h3344);
    repeat (5) slot(0, 0, 0, '0);
    frame("R7 mid-frame sample in next frame");

    // R9: handshake in the frame-start cycle
    exp_q.push_back(16'h9A0B); tag_q.push_back("R9 bypass sample framed");
    slot(1, 0, 1, 16'h9A0B);
    repeat (8) slot(0, 0, 0, '0);

    // R11: strobe still high at the next fall
    send(16'hC3D4);
    exp_q.push_back(16'hC3D4); tag_q.push_back("R11 held strobe no restart"); pend = 0;
    slot(1, 1, 0, '0);
    slot(1, 0, 0, '0);
    repeat (7) slot(0, 0, 0, '0);
    repeat (2) slot(0, 0, 0, '0);

    // R10: CDMA mode
    mon_en = 0;
    send(16'h7788);
    fm_mode = 0; cdma_bits = 2'b10;
    #1;
    check(pin_out == 2'b10, "R10 pins follow cdma", {14'd0, pin_out}, 16'h2);
    check(smp_ready == 0, "R10 ready low", {15'd0, smp_ready}, 16'd0);
    cdma_bits = 2'b01;
    #1;
    check(pin_out == 2'b01, "R10 pins follow cdma", {14'd0, pin_out}, 16'h1);
    @(negedge clk);
    cdma_bits = 2'b11;
    slot(1, 0, 0, '0);
    check(pin_out == 2'b11, "R10 strobe ignored in cdma mode", {14'd0, pin_out}, 16'h3);
    pend = 0;
    fm_mode = 1;
    @(negedge clk);
    check(pin_out == 2'b00, "R10 low after return", {14'd0, pin_out}, 16'd0);
    check(smp_ready == 1, "R10 slot emptied", {15'd0, smp_ready}, 16'd1);
    mon_en = 1;
    frame("R10 stale sample discarded");
    slot(0, 0, 0, '0);

    check(exp_q.size() == 0, "R3 all frames seen", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule